// File: doc/BRIEF.md
# Two-Entry Register Slice with Optional Overwrite-Newest Mode

This block is a two-entry ready/valid register stage placed between a producer and a consumer. It breaks every combinational path from the consumer's ready back to the producer's ready: the upstream ready, the downstream valid and the downstream data all come straight from flops. While one word waits for the consumer, the stage still accepts a second one. A producer that runs an iterative computation can therefore start its next job before the previous result has been taken.

With the parameter `CIRCULAR` at 0 the stage applies backpressure once both entries are occupied. With `CIRCULAR` at 1 it never stalls the producer. When full, a new word replaces the younger of the two held words and the older one stays at the output. The consumer therefore always finds the freshest value, and intermediate values are dropped. A synchronous `clear` empties the stage. An asynchronous active-low reset puts it in the same empty state.

Top module: `circ_skid_stage`

## Requirements
- R1: A word enters only at a rising edge where `in_valid` and `in_ready` are both 1. A word leaves only at a rising edge where `out_valid` and `out_ready` are both 1. Every word accepted is held until it leaves. In circular mode a word can also be displaced as described in R9.
- R2: `in_ready` is a registered output. Changing `out_ready` or `in_valid` within a cycle never changes `in_ready` in that cycle.
- R3: In every cycle in which the stage holds zero or one word, `in_ready` is 1.
- R4: In normal mode (`CIRCULAR`=0), `in_ready` is 0 in every cycle in which the stage holds two words. The stage leaves that state only through a read by the consumer or through `clear`.
- R5: In normal mode, words appear on `out_data` in acceptance order, each exactly once.
- R6: While `out_valid` is 1 and `out_ready` is 0 (and `clear` is 0), `out_valid` and `out_data` stay unchanged at the next edge.
- R7: A `clear` at a rising edge leaves the stage empty after that edge, with `out_valid` 0 and `in_ready` 1. This holds whatever the other inputs are.
- R8: In circular mode (`CIRCULAR`=1), `in_ready` is 1 in every cycle after reset.
- R9: In circular mode, a word accepted while two are held replaces the younger held word. The older word stays on `out_data` until it is read.
- R10: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R11: A word accepted into an empty stage is on `out_data` with `out_valid` 1 in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous empty request |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Stage can accept a word (registered) |
| in_data | input | DATA_W | Producer word |
| out_valid | output | 1 | Stage offers a word (registered) |
| out_ready | input | 1 | Consumer takes the offered word |
| out_data | output | DATA_W | Oldest held word (registered) |

## Verification
Every output of this stage is due exactly one edge after the stimulus that causes it. That covers a word accepted into an empty stage, the `in_ready` drop on filling, its rise after a drain, and the result of `clear`. The bench therefore drives inputs at the falling edge and checks the state the previous rising edge produced against a two-slot occupancy model. It also re-reads `in_ready` one time unit after driving new inputs, to show that the same-cycle inputs have no effect on it. The inputs sweep every pairing of 4-bit valid and ready patterns, with an occasional clear, on a normal and a circular instance side by side.

// File: rtl/csk_pkg.sv
package csk_pkg;
  typedef enum logic [1:0] {
    FILL_EMPTY = 2'd0,
    FILL_ONE   = 2'd1,
    FILL_TWO   = 2'd2
  } fill_e;
endpackage

// File: rtl/csk_ctrl.sv
module csk_ctrl
  import csk_pkg::*;
#(
  parameter int CIRCULAR = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic head_ld_in,
  output logic head_ld_tail,
  output logic tail_ld_in
);
  fill_e fill_q, fill_n;
  logic  rdy_q, rdy_n;
  logic  vld_q, vld_n;
  logic  take, give;

  assign take = in_valid & rdy_q;
  assign give = vld_q & out_ready;

  always_comb begin
    fill_n       = fill_q;
    head_ld_in   = 1'b0;
    head_ld_tail = 1'b0;
    tail_ld_in   = 1'b0;
    if (clear) begin
      fill_n = FILL_EMPTY;
    end else begin
      unique case (fill_q)
        FILL_EMPTY: begin
          if (take) begin
            head_ld_in = 1'b1;
            fill_n     = FILL_ONE;
          end
        end
        FILL_ONE: begin
          if (take && give) begin
            head_ld_in = 1'b1;
          end else if (take) begin
            tail_ld_in = 1'b1;
            fill_n     = FILL_TWO;
          end else if (give) begin
            fill_n = FILL_EMPTY;
          end
        end
        FILL_TWO: begin
          if (give) begin
            head_ld_tail = 1'b1;
            if (take) tail_ld_in = 1'b1;
            else      fill_n     = FILL_ONE;
          end else if (take) begin
            tail_ld_in = 1'b1;
          end
        end
        default: fill_n = FILL_EMPTY;
      endcase
    end
  end

  generate
    if (CIRCULAR != 0) begin : g_circ
      assign rdy_n = 1'b1;
    end else begin : g_norm
      assign rdy_n = (fill_n != FILL_TWO);
    end
  endgenerate

  assign vld_n = (fill_n != FILL_EMPTY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= FILL_EMPTY;
      rdy_q  <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      fill_q <= fill_n;
      rdy_q  <= rdy_n;
      vld_q  <= vld_n;
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = vld_q;

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fill_q == FILL_EMPTY) && !out_valid && in_ready);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CIRCULAR == 0 && fill_q == FILL_TWO) |-> !take);

  // R4
  fill_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CIRCULAR == 0 && fill_q == FILL_ONE && take && !give && !clear) |=> !in_ready);

  // R8
  circ_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CIRCULAR != 0) |-> in_ready);
endmodule

// File: rtl/csk_store.sv
module csk_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_ld_in,
  input  logic              head_ld_tail,
  input  logic              tail_ld_in,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] head_data
);
  logic [DATA_W-1:0] head_q, head_n, tail_q;
  logic              head_en;

  assign head_en = head_ld_in | head_ld_tail;
  assign head_n  = head_ld_tail ? tail_q : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       head_q <= '0;
    else if (head_en) head_q <= head_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tail_q <= '0;
    else if (tail_ld_in) tail_q <= in_data;
  end

  assign head_data = head_q;

  // R5
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(head_ld_in && head_ld_tail));
endmodule

// File: rtl/circ_skid_stage.sv
module circ_skid_stage #(
  parameter int DATA_W   = 8,
  parameter int CIRCULAR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic head_ld_in, head_ld_tail, tail_ld_in;

  csk_ctrl #(.CIRCULAR(CIRCULAR)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (clear),
    .in_valid     (in_valid),
    .out_ready    (out_ready),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .head_ld_in   (head_ld_in),
    .head_ld_tail (head_ld_tail),
    .tail_ld_in   (tail_ld_in)
  );

  csk_store #(.DATA_W(DATA_W)) i_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_ld_in   (head_ld_in),
    .head_ld_tail (head_ld_tail),
    .tail_ld_in   (tail_ld_in),
    .in_data      (in_data),
    .head_data    (out_data)
  );

  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear) |=> out_valid && $stable(out_data));

  // R11
  fill_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && in_valid && in_ready && !clear) |=> out_valid && (out_data == $past(in_data)));
endmodule

// File: tb/test_circ_skid_stage.sv
module test_circ_skid_stage;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         rdy_n_o, vld_n_o, rdy_c_o, vld_c_o;
  logic [W-1:0] dat_n_o, dat_c_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  int           cnt_n = 0, cnt_c = 0;
  logic [W-1:0] q0_n = '0, q1_n = '0, q0_c = '0, q1_c = '0;
  logic         pv_n = 0, pv_c = 0, pr = 0, pclr = 0;
  logic [W-1:0] pd_n = '0, pd_c = '0;
  logic [W-1:0] seq = 8'h01;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_skid_stage #(.DATA_W(W), .CIRCULAR(0)) i_circ_skid_stage (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_ready(rdy_n_o), .in_data(in_data), .out_valid(vld_n_o),
    .out_ready(out_ready), .out_data(dat_n_o));

  circ_skid_stage #(.DATA_W(W), .CIRCULAR(1)) i_circ_skid_stage_circ (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_ready(rdy_c_o), .in_data(in_data), .out_valid(vld_c_o),
    .out_ready(out_ready), .out_data(dat_c_o));

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input bit circ, input logic v, input logic r, input logic clr,
                       input logic [W-1:0] d, inout int cnt,
                       inout logic [W-1:0] q0, inout logic [W-1:0] q1);
    logic take, give;
    take = v && (circ || cnt < 2);
    give = r && cnt > 0;
    if (clr) begin
      cnt = 0;
    end else begin
      if (give) begin q0 = q1; cnt--; end
      if (take) begin
        if (cnt == 0)      begin q0 = d; cnt = 1; end
        else if (cnt == 1) begin q1 = d; cnt = 2; end
        else               q1 = d;
      end
    end
  endtask

  task automatic step(input logic v, input logic r, input logic clr);
    @(negedge clk);
    chk("R1", "normal out_valid", vld_n_o, cnt_n > 0);
    chk("R1", "circ out_valid", vld_c_o, cnt_c > 0);
    if (cnt_n > 0) chk("R5", "normal out_data", dat_n_o, q0_n);
    if (cnt_c > 0) chk("R9", "circ out_data", dat_c_o, q0_c);
    if (pv_n && !pr && !pclr) chk("R6", "normal held data", dat_n_o, pd_n);
    if (pv_c && !pr && !pclr) chk("R6", "circ held data", dat_c_o, pd_c);
    in_valid = v; out_ready = r; clear = clr; in_data = seq;
    #1;
    // R2: ready read after the same-cycle inputs changed
    chk(cnt_n < 2 ? "R3" : "R4", "normal in_ready", rdy_n_o, cnt_n < 2);
    chk("R2", "circ in_ready", rdy_c_o, 1);
    chk("R8", "circ ready after inputs", rdy_c_o, 1);
    pv_n = vld_n_o; pv_c = vld_c_o; pd_n = dat_n_o; pd_c = dat_c_o;
    pr = r; pclr = clr;
    model(0, v, r, clr, seq, cnt_n, q0_n, q1_n);
    model(1, v, r, clr, seq, cnt_c, q0_c, q1_c);
    seq = seq + 8'd1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R10", "reset out_valid", vld_n_o, 0);
    chk("R10", "reset in_ready", rdy_n_o, 1);
    chk("R10", "reset circ in_ready", rdy_c_o, 1);
    @(negedge clk); rst_n = 1'b1;

    for (int vp = 0; vp < 16; vp++)
      for (int rp = 0; rp < 16; rp++)
        for (int c = 0; c < 12; c++)
          step(vp[c%4], rp[(c*3+1)%4], (c == 11) && (vp == rp));

    // R7: fill to two, then clear while offering more
    step(0, 0, 1);
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 0, 1);
    @(negedge clk);
    chk("R7", "out_valid after clear", vld_n_o, 0);
    chk("R7", "in_ready after clear", rdy_n_o, 1);
    chk("R7", "circ out_valid after clear", vld_c_o, 0);

    // R11: single word into empty stage
    in_valid = 1; out_ready = 0; clear = 0; in_data = 8'hA5;
    @(negedge clk);
    in_valid = 0;
    chk("R11", "out_valid one cycle later", vld_n_o, 1);
    chk("R11", "out_data one cycle later", dat_n_o, 8'hA5);
    chk("R11", "circ out_data one cycle later", dat_c_o, 8'hA5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule